// File: doc/BRIEF.md
# Sampling Converter Bus Control

This block is the digital control side of a sampling converter that presents its result on a parallel bus. Two active control inputs drive it. `sel_n` is an active-low select. `read_mode` chooses between reading, when it is high, and converting, when it is low. A falling edge on either line can start a conversion, and which one does depends on the level of the other line. The same two lines decide when the data pins are driven. While a conversion runs, the block holds `busy` low and `hold` high.

A stand-in conversion engine replaces the analog core. It counts a fixed number of clock cycles. On the last cycle it copies the `probe_in` port into the result register. The block runs on one system clock. Both control inputs pass through a two-flop synchroniser, and edge detection works on the synchronised levels.

The block has three states:
- IDLE: no conversion is running and the bus is not driven.
- CONV: a conversion is running and the sample stage is in hold.
- READ: the result is offered on the bus.

It has six transitions:
- IDLE→CONV and READ→CONV on a start request.
- IDLE→READ on a read request.
- CONV→READ at the end of a conversion while select is low and read_mode is high.
- CONV→IDLE at the end of a conversion otherwise.
- READ→IDLE when select goes high or read_mode goes low.

Top module: `conv_bus_iface`

## Requirements
- R1: While the synchronised select is low and no conversion runs, a falling edge of `read_mode` starts a conversion: `busy` goes low and `hold` goes high.
- R2: While the synchronised `read_mode` is low and no conversion runs, a falling edge of `sel_n` starts a conversion. With `sel_n` high, a falling edge of `read_mode` starts nothing.
- R3: While select is low and no conversion runs, a rising edge of `read_mode` sets every bit of `dout_oe` to 1.
- R4: While `read_mode` is high and no conversion runs, a falling edge of `sel_n` sets every bit of `dout_oe` to 1.
- R5: `dout_oe` is all zeros whenever the synchronised `sel_n` is high, the synchronised `read_mode` is low, or a conversion runs.
- R6: `busy` stays low for exactly CONV_CYCLES clock cycles per conversion. `hold` is high exactly while `busy` is low.
- R7: If select is low and `read_mode` is high when a conversion ends, `dout_oe` is all ones and `dout` holds the new result in the same cycle that `busy` rises.
- R8: `dout[0]` carries the least significant bit of the result. Bit i of `dout` equals bit i of the sampled value.
- R9: Start requests that arrive during a conversion are ignored. They neither restart nor lengthen the conversion.
- R10: The result equals `probe_in` as it stands in the last conversion cycle. It is held unchanged until the next conversion ends.
- R11: After reset, `busy` is 1, `hold` is 0, `dout_oe` is all zeros and `dout` is zero.
- R12: A start edge applied on the inputs makes `busy` fall on the third rising clock edge after the change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| read_mode | input | 1 | High selects read, low selects convert |
| probe_in | input | DATA_W | Value captured by the stand-in conversion |
| busy | output | 1 | Low while a conversion runs |
| hold | output | 1 | High while the sample stage is in hold |
| dout | output | DATA_W | Result register, LSB on bit 0 |
| dout_oe | output | DATA_W | Per-pin output enable for `dout` |

## Verification
Conversions are started both by a `read_mode` fall with select low and by a select fall with `read_mode` low. These two cases show that each start path works on its own. A `read_mode` fall with select high is applied as well, to show that the level gating blocks a start. Reads are opened by a `read_mode` rise with select held low and by a select fall with `read_mode` high. A third read case ends a conversion with select low and `read_mode` high, to tell the automatic read at completion apart from the edge-opened reads. A further sequence toggles both lines and changes `probe_in` during a conversion. It separates a conversion that ignores late requests and samples at its final cycle from one that restarts or samples early.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } cbi_state_t;

    localparam int CTL_SEL  = 1;
    localparam int CTL_READ = 0;
    localparam int CTL_W    = 2;

endpackage

// File: rtl/cbi_sync.sv
module cbi_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cbi_edge.sv
module cbi_edge #(
    parameter int               WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] lvl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_d <= RESET_VAL;
        else        lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/cbi_engine.sv
module cbi_engine #(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] sample,
    output logic              last,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = run && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (!run||last) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    result <= '0;
        else if (last) result <= sample;
    end

endmodule

// File: rtl/conv_bus_iface.sv
module conv_bus_iface
    import cbi_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              read_mode,
    input  logic [DATA_W-1:0] probe_in,
    output logic              busy,
    output logic              hold,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe
);

    localparam int               SYNC_STAGES = 2;
    localparam logic [CTL_W-1:0] CTL_IDLE    = '1;

    cbi_state_t state_q, state_d;

    logic [CTL_W-1:0] ctl_s, ctl_rise, ctl_fall;
    logic sel_s, rm_s, sel_fall, rm_fall, rm_rise;
    logic conv_req, read_req, conv_last, bus_drive;
    logic [DATA_W-1:0] result;

    cbi_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_IDLE)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d ({sel_n, read_mode}),
        .q (ctl_s)
    );

    cbi_edge #(.WIDTH(CTL_W), .RESET_VAL(CTL_IDLE)) u_edge (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (ctl_s),
        .rise (ctl_rise),
        .fall (ctl_fall)
    );

    assign sel_s    = ctl_s[CTL_SEL];
    assign rm_s     = ctl_s[CTL_READ];
    assign sel_fall = ctl_fall[CTL_SEL];
    assign rm_fall  = ctl_fall[CTL_READ];
    assign rm_rise  = ctl_rise[CTL_READ];

    assign conv_req = (!sel_s && rm_fall) || (!rm_s && sel_fall);
    assign read_req = (!sel_s && rm_rise) || (rm_s && sel_fall);

    cbi_engine #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_engine (
        .clk (clk),
        .rst_n (rst_n),
        .run (state_q == ST_CONV),
        .sample (probe_in),
        .last (conv_last),
        .result (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_req)      state_d = ST_CONV;
                else if (read_req) state_d = ST_READ;
            end
            ST_CONV: begin
                if (conv_last) state_d = (!sel_s && rm_s) ? ST_READ : ST_IDLE;
            end
            ST_READ: begin
                if (conv_req)           state_d = ST_CONV;
                else if (sel_s || !rm_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != ST_CONV);
        hold      = (state_q == ST_CONV);
        bus_drive = (state_q == ST_READ) && !sel_s && rm_s;
        dout      = result;
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_pin_oe
        assign dout_oe[b] = bus_drive;
    end

endmodule

// File: rtl/cbi_checker.sv
module cbi_checker #(
    parameter int W = 12,
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_s,
    input logic         rm_s,
    input logic         sel_fall,
    input logic         rm_fall,
    input logic         rm_rise,
    input logic         busy,
    input logic [W-1:0] dout,
    input logic [W-1:0] dout_oe,
    input logic [W-1:0] probe_in
);

    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= 0;
        else           run_len <= run_len + 1;
    end

    assert_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s || !rm_s || !busy) |-> (dout_oe == '0));

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_s && rm_fall) |=> !busy);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rm_s && sel_fall) |=> !busy);

    assert_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sel_s && rm_rise) |=> (dout_oe == '1 || sel_s || !rm_s));

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (run_len == N));

    assert_valid_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !sel_s && rm_s) |-> (dout_oe == '1 && dout == $past(probe_in)));

    assert_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dout == $past(probe_in)));

    assert_uniform_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe == '0) || (dout_oe == '1));

endmodule

bind conv_bus_iface cbi_checker #(.W(DATA_W), .N(CONV_CYCLES)) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .sel_s (sel_s),
    .rm_s (rm_s),
    .sel_fall (sel_fall),
    .rm_fall (rm_fall),
    .rm_rise (rm_rise),
    .busy (busy),
    .dout (dout),
    .dout_oe (dout_oe),
    .probe_in (probe_in)
);

// File: tb/conv_bus_iface_test.sv
module conv_bus_iface_test;

    localparam int W = 8;
    localparam int N = 8;

    typedef struct packed {
        logic         sel;
        logic         rm;
        logic [W-1:0] probe;
        logic [4:0]   wt;
        logic         exp_busy;
        logic         exp_oe;
        logic [W-1:0] exp_dout;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 8'h00, 5'd5,  1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'h00, 5'd5,  1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b0, 8'hA5, 5'd4,  1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b0, 8'hA5, 5'd12, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h3C, 5'd5,  1'b1, 1'b1, 8'hA5},
        '{1'b1, 1'b1, 8'h3C, 5'd5,  1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h3C, 5'd5,  1'b1, 1'b1, 8'hA5},
        '{1'b0, 1'b0, 8'h3C, 5'd4,  1'b0, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h3C, 5'd12, 1'b1, 1'b1, 8'h3C},
        '{1'b1, 1'b1, 8'h3C, 5'd5,  1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 8'h3C, 5'd4,  1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b0, 8'h81, 5'd12, 1'b1, 1'b0, 8'h00},
        '{1'b0, 1'b1, 8'h81, 5'd5,  1'b1, 1'b1, 8'h81}
    };

    localparam string VTAG [NV] = '{
        "R11", "R2", "R2", "R5", "R3", "R5", "R4", "R1", "R7", "R5", "R2", "R10", "R8"
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_n = 1'b1;
    logic         read_mode = 1'b1;
    logic [W-1:0] probe_in = '0;
    logic         busy, hold;
    logic [W-1:0] dout, dout_oe;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    conv_bus_iface #(.DATA_W(W), .CONV_CYCLES(N)) uut (
        .clk (clk),
        .rst_n (rst_n),
        .sel_n (sel_n),
        .read_mode (read_mode),
        .probe_in (probe_in),
        .busy (busy),
        .hold (hold),
        .dout (dout),
        .dout_oe (dout_oe)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int low_cnt;
        repeat (3) @(negedge clk);
        // R11: reset state, before release and just after it
        check("R11", "busy", 32'(busy), 32'd1);
        check("R11", "hold", 32'(hold), 32'd0);
        check("R11", "oe", 32'(dout_oe), 32'd0);
        check("R11", "dout", 32'(dout), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11", "busy after release", 32'(busy), 32'd1);

        for (int i = 0; i < NV; i++) begin
            sel_n     = VEC[i].sel;
            read_mode = VEC[i].rm;
            probe_in  = VEC[i].probe;
            repeat (int'(VEC[i].wt)) @(negedge clk);
            check(VTAG[i], "busy", 32'(busy), 32'(VEC[i].exp_busy));
            check("R6", "hold", 32'(hold), 32'(!VEC[i].exp_busy));
            check(VTAG[i], "oe", 32'(dout_oe), VEC[i].exp_oe ? 32'hFF : 32'h0);
            if (VEC[i].exp_oe) check(VTAG[i], "dout", 32'(dout), 32'(VEC[i].exp_dout));
        end

        // R12: latency through synchroniser and edge detector
        sel_n = 1'b1; read_mode = 1'b0;
        repeat (6) @(negedge clk);
        sel_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R12", "busy after 2 edges", 32'(busy), 32'd1);
        @(negedge clk);
        check("R12", "busy after 3 edges", 32'(busy), 32'd0);
        low_cnt = 1;
        while (busy == 1'b0 && low_cnt < 100) begin
            @(negedge clk);
            if (busy == 1'b0) low_cnt++;
        end
        check("R6", "busy low cycles", 32'(low_cnt), 32'(N));

        // R9 and R10: requests during a conversion ignored, sample at end
        sel_n = 1'b1; read_mode = 1'b1; probe_in = 8'h5A;
        repeat (6) @(negedge clk);
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        read_mode = 1'b0;
        while (busy == 1'b1) @(negedge clk);
        low_cnt = 1;
        while (busy == 1'b0 && low_cnt < 100) begin
            if (low_cnt == 1) read_mode = 1'b1;
            if (low_cnt == 2) sel_n = 1'b1;
            if (low_cnt == 3) begin sel_n = 1'b0; read_mode = 1'b0; probe_in = 8'hC3; end
            if (low_cnt == 5) read_mode = 1'b1;
            @(negedge clk);
            if (busy == 1'b0) low_cnt++;
        end
        check("R9", "busy low cycles with late requests", 32'(low_cnt), 32'(N));
        check("R7", "oe at busy rise", 32'(dout_oe), 32'hFF);
        check("R10", "result sampled at end", 32'(dout), 32'hC3);
        probe_in = 8'h11;
        repeat (4) @(negedge clk);
        check("R10", "result held", 32'(dout), 32'hC3);
        check("R8", "lsb pin", 32'(dout[0]), 32'd1);

        finish_run();
    end

endmodule